// File: doc/BRIEF.md
# Single-Bit Fault Key-Byte Recovery Engine

This block recovers one byte of the final AES-128 round key. It takes pairs of ciphertext bytes taken at the same position: one from a correct run and one from a run in which a single bit was flipped at the input of the last SubBytes step. The work is done one byte at a time, so the byte position permutation of the last round plays no part. The per-byte model is `C = SB(x) xor K`, where `x` is the byte before the substitution and `K` is the key byte.

For each accepted pair the engine forms the difference `d = correct xor faulty`. It then tests every pair `(x, e)`, where `x` runs over all 256 byte values and `e` over the 8 single-bit patterns. One pair is tested per clock. A pair is consistent when `SB(x xor e) xor SB(x) == d`. Each consistent pair marks the candidate `SB(x xor e) xor faulty` in a 256-bit per-pair set. When the sweep ends, that set is intersected with a running candidate set.

The engine keeps accepting pairs until one candidate is left. A clear command starts a new recovery.

Top module: `keybyte_recover`

## Requirements
- R1: After reset, and in the cycle after a one-cycle `clear_i` pulse, `cand_mask_o` is all ones, `cand_count_o` is 256, `unique_o` and `empty_o` are 0, and `done_o` is 0.
- R2: A pair accepted with `corr_i == fault_i` makes `err_o` high for exactly the one cycle after the accepting edge. It leaves `cand_mask_o` unchanged, starts no sweep, and `pair_ready_o` stays high.
- R3: A pair accepted with a non-zero difference drops `pair_ready_o` until the sweep ends. `done_o` pulses for one cycle, becoming high 2049 clock edges after the accepting edge, and `pair_ready_o` is high again in that same cycle.
- R4: The first pair completed after reset or clear replaces the running set. Bit `k` of `cand_mask_o` is 1 exactly when some byte `x` and bit position `b` give `SB(x ^ (1<<b)) ^ SB(x) == corr ^ faulty` and `SB(x ^ (1<<b)) ^ faulty == k`. `SB` is the AES forward S-box.
- R5: Every later completed pair ANDs its per-pair set (defined as in R4) into `cand_mask_o`. Bits are never set again except by clear or reset.
- R6: `cand_count_o` equals the number of ones in `cand_mask_o`.
- R7: `unique_o` is 1 exactly when the count is 1, and `unique_idx_o` then gives the bit position of the remaining candidate. For pairs built from one key byte, the remaining candidate is that key byte.
- R8: `empty_o` is 1 exactly when the count is 0.
- R9: A clear during a sweep abandons that sweep. No `done_o` follows, the set is all ones, and the next pair is treated as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Start a new recovery (set all ones, next pair replaces) |
| pair_valid_i | input | 1 | Pair offered |
| pair_ready_o | output | 1 | Engine idle and able to take a pair |
| corr_i | input | 8 | Correct ciphertext byte |
| fault_i | input | 8 | Faulty ciphertext byte |
| err_o | output | 1 | One-cycle pulse: zero-difference pair rejected |
| done_o | output | 1 | One-cycle pulse: sweep merged into the running set |
| cand_mask_o | output | 256 | Running key-byte candidate bitmap |
| cand_count_o | output | 9 | Number of candidates remaining |
| unique_o | output | 1 | Exactly one candidate remains |
| unique_idx_o | output | 8 | Lowest remaining candidate (the key byte when unique) |
| empty_o | output | 1 | No candidate remains |

## Verification
The hardest state to reach from the ports is an empty intersection. Pairs that come from one real key byte never empty the set. To get there, the bench feeds pairs whose differences are random and unrelated, until its own model predicts zero candidates. A clear that lands in the middle of a 2048-cycle sweep is also hard to hit by chance. The bench therefore issues that clear on purpose about a hundred cycles into a sweep, and then watches that no merge follows.

// File: rtl/kbr_pkg.sv
package kbr_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned N_VAL     = 1 << BYTE_W;
  localparam int unsigned BIT_IDX_W = $clog2(BYTE_W);
  localparam int unsigned HYP_W     = BYTE_W + BIT_IDX_W;
  localparam int unsigned CNT_W     = BYTE_W + 1;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic [1:0] {ST_IDLE, ST_SWEEP, ST_MERGE} state_e;

  function automatic byte_t gf_mul(byte_t a, byte_t b);
    byte_t p;
    byte_t x;
    p = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  // x^254 = multiplicative inverse (0 maps to 0)
  function automatic byte_t gf_inv(byte_t a);
    byte_t r;
    byte_t b;
    r = 8'h01;
    b = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gf_mul(r, b);
      b = gf_mul(b, b);
    end
    return r;
  endfunction

  function automatic byte_t sbox(byte_t a);
    byte_t v;
    v = gf_inv(a);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
             ^ {v[3:0], v[7:4]} ^ 8'h63;
  endfunction
endpackage

// File: rtl/kbr_sbox.sv
module kbr_sbox
  import kbr_pkg::*;
(
  input  byte_t x_i,
  output byte_t y_o
);
  assign y_o = sbox(x_i);
endmodule

// File: rtl/kbr_sweep.sv
module kbr_sweep
  import kbr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  byte_t            diff_i,
  input  byte_t            fault_i,
  output logic [N_VAL-1:0] pair_mask_o,
  output logic             last_o
);
  logic [HYP_W-1:0] cnt_q;
  byte_t            diff_q, fault_q;
  logic [N_VAL-1:0] pmask_q;
  byte_t            m, e, sb_me, sb_m, cand;
  logic             hit;

  assign m    = cnt_q[HYP_W-1:BIT_IDX_W];
  assign e    = byte_t'(1) << cnt_q[BIT_IDX_W-1:0];

  kbr_sbox u_sb_flip (.x_i(m ^ e), .y_o(sb_me));
  kbr_sbox u_sb_good (.x_i(m),     .y_o(sb_m));

  assign hit    = (sb_me ^ sb_m) == diff_q;
  assign cand   = sb_me ^ fault_q;
  assign last_o = run_i && (cnt_q == '1);
  assign pair_mask_o = pmask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      diff_q  <= '0;
      fault_q <= '0;
      pmask_q <= '0;
    end else if (start_i) begin
      cnt_q   <= '0;
      diff_q  <= diff_i;
      fault_q <= fault_i;
      pmask_q <= '0;
    end else if (run_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (hit) pmask_q[cand] <= 1'b1;
    end
  end
endmodule

// File: rtl/kbr_popcnt.sv
module kbr_popcnt
  import kbr_pkg::*;
(
  input  logic [N_VAL-1:0] mask_i,
  output logic [CNT_W-1:0] count_o,
  output byte_t            low_idx_o
);
  always_comb begin
    count_o   = '0;
    low_idx_o = '0;
    for (int i = N_VAL - 1; i >= 0; i--) begin
      count_o = count_o + CNT_W'(mask_i[i]);
      if (mask_i[i]) low_idx_o = byte_t'(i);
    end
  end
endmodule

// File: rtl/keybyte_recover.sv
module keybyte_recover
  import kbr_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         pair_valid_i,
  output logic         pair_ready_o,
  input  logic [7:0]   corr_i,
  input  logic [7:0]   fault_i,
  output logic         err_o,
  output logic         done_o,
  output logic [255:0] cand_mask_o,
  output logic [8:0]   cand_count_o,
  output logic         unique_o,
  output logic [7:0]   unique_idx_o,
  output logic         empty_o
);
  state_e           state_q;
  logic             first_q, err_q, done_q;
  logic [N_VAL-1:0] run_mask_q, pair_mask;
  logic             accept, zero_diff, sweep_last;
  byte_t            diff;

  assign diff         = corr_i ^ fault_i;
  assign zero_diff    = diff == '0;
  assign pair_ready_o = (state_q == ST_IDLE) && !clear_i;
  assign accept       = pair_valid_i && pair_ready_o;

  kbr_sweep u_sweep (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept && !zero_diff),
    .run_i      (state_q == ST_SWEEP),
    .diff_i     (diff),
    .fault_i    (fault_i),
    .pair_mask_o(pair_mask),
    .last_o     (sweep_last)
  );

  kbr_popcnt u_popcnt (
    .mask_i   (run_mask_q),
    .count_o  (cand_count_o),
    .low_idx_o(unique_idx_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      first_q    <= 1'b1;
      run_mask_q <= '1;
      err_q      <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      err_q  <= 1'b0;
      done_q <= 1'b0;
      if (clear_i) begin
        state_q    <= ST_IDLE;
        first_q    <= 1'b1;
        run_mask_q <= '1;
      end else begin
        unique case (state_q)
          ST_IDLE: if (accept) begin
            if (zero_diff) err_q   <= 1'b1;
            else           state_q <= ST_SWEEP;
          end
          ST_SWEEP: if (sweep_last) state_q <= ST_MERGE;
          ST_MERGE: begin
            run_mask_q <= first_q ? pair_mask : (run_mask_q & pair_mask);
            first_q    <= 1'b0;
            done_q     <= 1'b1;
            state_q    <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign err_o       = err_q;
  assign done_o      = done_q;
  assign cand_mask_o = run_mask_q;
  assign unique_o    = cand_count_o == CNT_W'(1);
  assign empty_o     = cand_count_o == '0;
endmodule

// File: rtl/kbr_checker.sv
module kbr_checker (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         clear_i,
  input logic         pair_ready_o,
  input logic         err_o,
  input logic         done_o,
  input logic [255:0] cand_mask_o,
  input logic [8:0]   cand_count_o,
  input logic         unique_o,
  input logic [7:0]   unique_idx_o,
  input logic         empty_o
);
  AST_CLEAR_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cand_mask_o == '1 && cand_count_o == 9'd256 && !done_o)); // R1

  AST_ERR_NO_SWEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> pair_ready_o || $past(clear_i)); // R2

  AST_ERR_MASK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !$past(clear_i)) |-> $stable(cand_mask_o)); // R2

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clear_i) |-> pair_ready_o); // R3

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3

  AST_MASK_SHRINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clear_i) |-> ((cand_mask_o & ~$past(cand_mask_o)) == '0)); // R5

  AST_UNIQUE_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unique_o |-> cand_mask_o[unique_idx_o]); // R7

  AST_EMPTY_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (cand_mask_o == '0 && !unique_o)); // R8
endmodule

bind keybyte_recover kbr_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clear_i     (clear_i),
  .pair_ready_o(pair_ready_o),
  .err_o       (err_o),
  .done_o      (done_o),
  .cand_mask_o (cand_mask_o),
  .cand_count_o(cand_count_o),
  .unique_o    (unique_o),
  .unique_idx_o(unique_idx_o),
  .empty_o     (empty_o)
);

// File: tb/keybyte_recover_tb.sv
module keybyte_recover_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0, rst_n = 1'b0, clear = 1'b0, valid = 1'b0;
  logic [7:0]   corr = '0, fault = '0;
  logic         ready, err, done, uniq, empty;
  logic [255:0] mask;
  logic [8:0]   count;
  logic [7:0]   uidx;

  int n_chk = 0, n_bad = 0;
  logic [7:0]   sb [256];
  logic [255:0] exp_mask = '1;
  logic         exp_first = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  keybyte_recover u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .pair_valid_i(valid),
    .pair_ready_o(ready), .corr_i(corr), .fault_i(fault), .err_o(err),
    .done_o(done), .cand_mask_o(mask), .cand_count_o(count),
    .unique_o(uniq), .unique_idx_o(uidx), .empty_o(empty)
  );

  function automatic logic [7:0] tb_mul(logic [7:0] a, logic [7:0] b);
    logic [7:0] p = '0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = (x << 1) ^ (x[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  // inverse by exhaustive search, then the fixed affine map
  function automatic logic [7:0] tb_sbox(logic [7:0] a);
    logic [7:0] inv = '0;
    logic [7:0] r;
    for (int y = 1; y < 256; y++)
      if (tb_mul(a, 8'(y)) == 8'h01) inv = 8'(y);
    r = 8'h63;
    for (int i = 0; i < 8; i++)
      r[i] = r[i] ^ inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
    return r;
  endfunction

  function automatic logic [255:0] pair_set(logic [7:0] c, logic [7:0] f);
    logic [255:0] s = '0;
    logic [7:0]   d = c ^ f;
    for (int m = 0; m < 256; m++)
      for (int b = 0; b < 8; b++) begin
        logic [7:0] me;
        me = 8'(m) ^ (8'd1 << b);
        if ((sb[me] ^ sb[8'(m)]) == d) s[sb[me] ^ f] = 1'b1;
      end
    return s;
  endfunction

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    exp_mask = '1; exp_first = 1'b1;
  endtask

  task automatic check_outputs(string req_mask);
    int n;
    n = $countones(exp_mask);
    chk(req_mask, mask, exp_mask);
    chk("R6 count", 256'(count), 256'(n));
    chk("R7 unique", 256'(uniq), 256'(n == 1));
    chk("R8 empty", 256'(empty), 256'(n == 0));
    if (n == 1) begin
      int k = 0;
      for (int i = 0; i < 256; i++) if (exp_mask[i]) k = i;
      chk("R7 index", 256'(uidx), 256'(k));
    end
  endtask

  task automatic send_pair(logic [7:0] c, logic [7:0] f, output int cyc);
    @(negedge clk); corr = c; fault = f; valid = 1'b1;
    @(posedge clk); #1 valid = 1'b0;
    chk("R3 ready low in sweep", 256'(ready), 256'(0));
    cyc = 0;
    while (!done && cyc < 3000) begin
      @(posedge clk); #1; cyc++;
    end
    chk("R3 latency", 256'(cyc), 256'(2049));
    chk("R3 ready at done", 256'(ready), 256'(1));
    exp_mask  = exp_first ? pair_set(c, f) : (exp_mask & pair_set(c, f));
    check_outputs(exp_first ? "R4 first pair replaces" : "R5 intersect");
    exp_first = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    int cyc;
    logic [7:0] key, x, c, f;
    int b;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 256; i++) sb[i] = tb_sbox(8'(i));

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset mask", mask, '1);
    chk("R1 reset count", 256'(count), 256'(256));
    chk("R1 reset flags", 256'({uniq, empty, done, err, ready}), 256'(5'b00001));

    // R2: zero difference rejected
    @(negedge clk); corr = 8'h5a; fault = 8'h5a; valid = 1'b1;
    @(posedge clk); #1 valid = 1'b0;
    chk("R2 err pulse", 256'(err), 256'(1));
    chk("R2 ready kept", 256'(ready), 256'(1));
    chk("R2 mask unchanged", mask, '1);
    @(posedge clk); #1;
    chk("R2 err one cycle", 256'(err), 256'(0));

    // R4 R5 R7: recover random key bytes
    for (int t = 0; t < 4; t++) begin
      key = 8'($urandom);
      pulse_clear();
      #1 chk("R1 clear full", mask, '1);
      for (int p = 0; p < 10; p++) begin
        x = 8'($urandom);
        b = (t == 0) ? ((p % 2) ? 7 : 0) : int'($urandom % 8);
        c = sb[x] ^ key;
        f = sb[x ^ (8'd1 << b)] ^ key;
        send_pair(c, f, cyc);
        if ($countones(exp_mask) == 1) break;
      end
      chk("R7 key found", 256'({uniq, uidx}), 256'({1'b1, key}));
    end

    // R8: unrelated differences until empty
    pulse_clear();
    for (int p = 0; p < 8; p++) begin
      c = 8'($urandom);
      f = c ^ 8'(1 + ($urandom % 255));
      send_pair(c, f, cyc);
      if (exp_mask == '0) break;
    end
    chk("R8 empty reached", 256'(empty), 256'(exp_mask == '0));

    // R9: clear mid-sweep
    @(negedge clk); corr = 8'h13; fault = 8'h17; valid = 1'b1;
    @(posedge clk); #1 valid = 1'b0;
    repeat (100) @(posedge clk);
    pulse_clear();
    cyc = 0;
    for (int i = 0; i < 2100; i++) begin
      @(posedge clk); #1;
      if (done) cyc++;
    end
    chk("R9 no done after abort", 256'(cyc), 256'(0));
    chk("R9 mask full", mask, '1);
    chk("R9 ready", 256'(ready), 256'(1));
    key = 8'hc4;
    x = 8'h2e;
    send_pair(sb[x] ^ key, sb[x ^ 8'h10] ^ key, cyc);

    summary();
    $finish;
  end
endmodule